// File: doc/BRIEF.md
# Cache Stall Cause Tracker

This block records why the request-accept path of a cache is stalled. Each stall cause owns one bit of a small cause mask. The queues around the cache send pulses that raise or drop a cause, and each pulse carries a cause index. While any bit of the mask is set, the block holds a blocked signal toward the request-side port.

The block also keeps two saturating statistics per cause. A stall episode is the interval in which the mask stays nonzero. The episode count of a cause increases when that cause opens an episode on an empty mask. The stall-cycle total of a cause grows by the length of an episode when a clear of that cause empties the mask. Episode length comes from a free-running cycle counter and a start stamp taken when the episode opens. A plain select input picks which cause's two counters appear on the read outputs.

Top module: `stall_tracker`

## Requirements
- R1: Cause indices are encoded as follows: 0 = no free miss register, 1 = no free write buffer, 2 = no free target slot. Cause c maps to bit c of `cause_mask`.
- R2: A valid set of cause c makes bit c of `cause_mask` one after the next clock edge. A valid clear of cause c makes that bit zero. Other bits are not changed.
- R3: `blocked` is high exactly when `cause_mask` is nonzero.
- R4: A valid set that arrives while the mask is zero adds one to that cause's episode count and records the current cycle as the episode start.
- R5: A set that arrives while the mask is already nonzero only adds its bit. It changes no episode count and no start stamp.
- R6: A clear that leaves the mask at zero adds the number of clock edges from the opening set to this clear to the stall-cycle total of the cause being cleared.
- R7: When a set and a clear arrive in the same cycle, the clear is applied first and then the set. A handoff from one cause to another therefore keeps the episode open. A set and a clear of the same cause on an empty mask open a new episode.
- R8: A clear of a cause whose bit is zero, while the mask is empty, has no effect: no episode end and no counter change.
- R9: Counters saturate instead of wrapping. With default parameters, the episode count stops at 255 and the stall-cycle total stops at 4095.
- R10: After reset the mask, `blocked` and all counters read zero.
- R11: A set or clear carrying cause index 3 (out of range) is ignored. Selecting index 3 on `rd_sel` reads zero on both statistic outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_valid | input | 1 | Raise-cause pulse |
| set_cause | input | 2 | Cause index for the raise pulse |
| clr_valid | input | 1 | Drop-cause pulse |
| clr_cause | input | 2 | Cause index for the drop pulse |
| rd_sel | input | 2 | Cause whose statistics are shown |
| blocked | output | 1 | Request-side stall, high when any cause is active |
| cause_mask | output | 3 | Active stall causes, bit c for cause c |
| rd_episodes | output | 8 | Episode count of the selected cause |
| rd_stall_cycles | output | 12 | Stall-cycle total of the selected cause |

## Verification
The bench drives each pulse on a falling edge. The mask, `blocked` and both counters change at the next rising edge, so every result is due exactly one edge after its stimulus. The driver pushes the expected state for that edge into a queue, and the monitor compares it two time units after the rising edge. This keeps sampling clear of the edge. The bench measures episode lengths by counting driven steps, one per edge, so the expected totals do not depend on the design's cycle counter.

// File: rtl/stall_pkg.sv
package stall_pkg;
  localparam int NUM_STALL_CAUSES = 3;

  typedef enum logic [1:0] {
    CAUSE_NO_MISS_REG = 2'd0,
    CAUSE_NO_WR_BUF   = 2'd1,
    CAUSE_NO_TARGET   = 2'd2
  } stall_cause_e;
endpackage

// File: rtl/stall_mask.sv
module stall_mask #(
  parameter int N  = 3,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_v,
  input  logic [IW-1:0] set_idx,
  input  logic          clr_v,
  input  logic [IW-1:0] clr_idx,
  output logic [N-1:0]  mask_q,
  output logic          ep_start,
  output logic          ep_end
);
  logic [N-1:0] set_bit, clr_bit, mid, nxt;
  logic         set_ok;

  assign set_ok = set_v && (int'(set_idx) < N);

  for (genvar i = 0; i < N; i++) begin : g_dec
    assign set_bit[i] = set_v && (set_idx == IW'(i));
    assign clr_bit[i] = clr_v && (clr_idx == IW'(i));
  end

  // clear first, then set
  assign mid      = mask_q & ~clr_bit;
  assign nxt      = mid | set_bit;
  assign ep_start = (mask_q == '0) && set_ok;
  assign ep_end   = (mask_q != '0) && (nxt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= nxt;
  end

  // R2
  set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_ok |=> mask_q[$past(set_idx)]);
  // R8
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0 && !set_v) |=> mask_q == '0);
endmodule

// File: rtl/stall_timebase.sv
module stall_timebase #(
  parameter int CYW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ep_start,
  output logic [CYW-1:0] dur
);
  logic [CYW-1:0] cyc_q, start_q;

  function automatic logic [CYW-1:0] elapsed(input logic [CYW-1:0] now,
                                             input logic [CYW-1:0] from);
    return now - from;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc_q   <= '0;
      start_q <= '0;
    end else begin
      cyc_q <= cyc_q + 1'b1;
      if (ep_start) start_q <= cyc_q;
    end
  end

  assign dur = elapsed(cyc_q, start_q);

  // R4
  start_stamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ep_start |=> start_q == $past(cyc_q));
  // R5
  stamp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ep_start |=> $stable(start_q));
endmodule

// File: rtl/stall_stats.sv
module stall_stats #(
  parameter int N    = 3,
  parameter int IW   = 2,
  parameter int EPW  = 8,
  parameter int TOTW = 12,
  parameter int CYW  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ep_start,
  input  logic [IW-1:0]   start_idx,
  input  logic            ep_end,
  input  logic [IW-1:0]   end_idx,
  input  logic [CYW-1:0]  dur,
  input  logic [IW-1:0]   rd_sel,
  output logic [EPW-1:0]  rd_ep,
  output logic [TOTW-1:0] rd_tot
);
  localparam int SW = ((TOTW > CYW) ? TOTW : CYW) + 1;
  localparam logic [EPW-1:0]  EP_MAX  = '1;
  localparam logic [TOTW-1:0] TOT_MAX = '1;

  logic [EPW-1:0]  ep_cnt  [N];
  logic [TOTW-1:0] tot_cnt [N];

  function automatic logic [EPW-1:0] sat_inc(input logic [EPW-1:0] v);
    return (v == EP_MAX) ? v : v + 1'b1;
  endfunction

  function automatic logic [TOTW-1:0] sat_add(input logic [TOTW-1:0] v,
                                              input logic [CYW-1:0]  d);
    logic [SW-1:0] s;
    s = SW'(v) + SW'(d);
    return (s > SW'(TOT_MAX)) ? TOT_MAX : s[TOTW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        ep_cnt[i]  <= '0;
        tot_cnt[i] <= '0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (ep_start && start_idx == IW'(i)) ep_cnt[i]  <= sat_inc(ep_cnt[i]);
        if (ep_end && end_idx == IW'(i))     tot_cnt[i] <= sat_add(tot_cnt[i], dur);
      end
    end
  end

  always_comb begin
    rd_ep  = '0;
    rd_tot = '0;
    for (int i = 0; i < N; i++) begin
      if (rd_sel == IW'(i)) begin
        rd_ep  = ep_cnt[i];
        rd_tot = tot_cnt[i];
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R9
    ep_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ep_cnt[i] >= $past(ep_cnt[i]));
    // R9
    tot_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tot_cnt[i] >= $past(tot_cnt[i]));
  end
endmodule

// File: rtl/stall_tracker.sv
module stall_tracker
  import stall_pkg::*;
#(
  parameter int N    = NUM_STALL_CAUSES,
  parameter int EPW  = 8,
  parameter int TOTW = 12,
  parameter int CYW  = 16,
  localparam int IW  = (N > 1) ? $clog2(N + 1) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_valid,
  input  logic [IW-1:0]   set_cause,
  input  logic            clr_valid,
  input  logic [IW-1:0]   clr_cause,
  input  logic [IW-1:0]   rd_sel,
  output logic            blocked,
  output logic [N-1:0]    cause_mask,
  output logic [EPW-1:0]  rd_episodes,
  output logic [TOTW-1:0] rd_stall_cycles
);
  logic           ep_start, ep_end;
  logic [CYW-1:0] dur;

  stall_mask #(.N(N), .IW(IW)) u_mask (
    .clk(clk), .rst_n(rst_n),
    .set_v(set_valid), .set_idx(set_cause),
    .clr_v(clr_valid), .clr_idx(clr_cause),
    .mask_q(cause_mask), .ep_start(ep_start), .ep_end(ep_end)
  );

  stall_timebase #(.CYW(CYW)) u_time (
    .clk(clk), .rst_n(rst_n), .ep_start(ep_start), .dur(dur)
  );

  stall_stats #(.N(N), .IW(IW), .EPW(EPW), .TOTW(TOTW), .CYW(CYW)) u_stats (
    .clk(clk), .rst_n(rst_n),
    .ep_start(ep_start), .start_idx(set_cause),
    .ep_end(ep_end), .end_idx(clr_cause), .dur(dur),
    .rd_sel(rd_sel), .rd_ep(rd_episodes), .rd_tot(rd_stall_cycles)
  );

  assign blocked = |cause_mask;

  // R3
  rise_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blocked) |-> $past(ep_start));
  // R6
  fall_needs_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(blocked) |-> $past(ep_end));
  // R7
  handoff_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blocked && set_valid && (int'(set_cause) < N)) |=> blocked);
endmodule

// File: tb/stall_tracker_bench.sv
module stall_tracker_bench;
  localparam int PER = 10;
  localparam int EPMAX = 255;
  localparam int TOTMAX = 4095;

  logic clk = 0, rst_n = 0;
  logic set_valid = 0, clr_valid = 0;
  logic [1:0] set_cause = 0, clr_cause = 0, rd_sel = 0;
  logic blocked;
  logic [2:0] cause_mask;
  logic [7:0] rd_episodes;
  logic [11:0] rd_stall_cycles;

  stall_tracker u_stall_tracker (
    .clk(clk), .rst_n(rst_n), .set_valid(set_valid), .set_cause(set_cause),
    .clr_valid(clr_valid), .clr_cause(clr_cause), .rd_sel(rd_sel),
    .blocked(blocked), .cause_mask(cause_mask),
    .rd_episodes(rd_episodes), .rd_stall_cycles(rd_stall_cycles)
  );

  always #(PER/2) clk = ~clk;

  typedef struct { int m; int ep; int cy; string req; } exp_t;
  exp_t q[$];
  int checks = 0, failures = 0;
  int m_mask = 0, m_start = 0, t = 0;
  int m_ep[3] = '{0, 0, 0};
  int m_cy[3] = '{0, 0, 0};
  bit done = 0;

  task automatic step(input bit sv, input int sc, input bit cv, input int cc,
                      input int sel, input string req);
    int sb, cb, mid, nx;
    exp_t e;
    @(negedge clk);
    set_valid = sv; set_cause = 2'(sc);
    clr_valid = cv; clr_cause = 2'(cc);
    rd_sel = 2'(sel);
    sb = (sv && sc < 3) ? (1 << sc) : 0;
    cb = (cv && cc < 3) ? (1 << cc) : 0;
    mid = m_mask & ~cb;
    nx = mid | sb;
    if (m_mask == 0 && sb != 0) begin
      m_ep[sc] = (m_ep[sc] >= EPMAX) ? EPMAX : m_ep[sc] + 1;
      m_start = t;
    end
    if (m_mask != 0 && nx == 0)
      m_cy[cc] = (m_cy[cc] + (t - m_start) > TOTMAX) ? TOTMAX : m_cy[cc] + (t - m_start);
    m_mask = nx;
    t++;
    e.m = m_mask;
    e.ep = (sel < 3) ? m_ep[sel] : 0;
    e.cy = (sel < 3) ? m_cy[sel] : 0;
    e.req = req;
    q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      while (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (blocked !== (e.m != 0) || cause_mask !== 3'(e.m) ||
            rd_episodes !== 8'(e.ep) || rd_stall_cycles !== 12'(e.cy)) begin
          failures++;
          $display("FAIL %s: got blk=%0b mask=%0d ep=%0d cy=%0d exp blk=%0b mask=%0d ep=%0d cy=%0d",
                   e.req, blocked, cause_mask, rd_episodes, rd_stall_cycles,
                   e.m != 0, e.m, e.ep, e.cy);
        end
      end
    end
  end

  initial begin : watchdog
    #(PER * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #2;
    // R10 reset state
    for (int s = 0; s < 3; s++) begin
      rd_sel = 2'(s);
      #1;
      checks++;
      if (blocked !== 0 || cause_mask !== 0 || rd_episodes !== 0 || rd_stall_cycles !== 0) begin
        failures++;
        $display("FAIL R10: got blk=%0b mask=%0d ep=%0d cy=%0d exp all 0",
                 blocked, cause_mask, rd_episodes, rd_stall_cycles);
      end
    end
    @(negedge clk);
    rst_n = 1;
    // R1 R2 R4: open on cause 0
    step(1, 0, 0, 0, 0, "R4 open cause0");
    // R5: further sets only add bits
    step(1, 2, 0, 0, 2, "R5 add cause2");
    step(1, 1, 0, 0, 0, "R5 add cause1");
    step(0, 0, 0, 0, 1, "R1 read cause1");
    step(0, 0, 1, 2, 2, "R2 clear cause2");
    step(0, 0, 1, 0, 0, "R2 clear cause0");
    step(0, 0, 0, 0, 1, "R3 still blocked");
    step(0, 0, 0, 0, 1, "R3 still blocked");
    // R6: clear empties, charged to cause1
    step(0, 0, 1, 1, 1, "R6 close on cause1");
    step(0, 0, 0, 0, 0, "R6 cause0 uncharged");
    // R8: clear an empty mask
    step(0, 0, 1, 1, 1, "R8 idle clear");
    step(0, 0, 0, 0, 1, "R8 no change");
    // R11: out-of-range index ignored
    step(1, 3, 0, 0, 3, "R11 bad set");
    step(0, 0, 1, 3, 3, "R11 bad clear");
    // R7: same-cycle handoff
    step(1, 1, 0, 0, 1, "R7 open cause1");
    step(0, 0, 0, 0, 1, "R7 hold");
    step(1, 2, 1, 1, 2, "R7 handoff 1 to 2");
    step(0, 0, 0, 0, 2, "R7 hold");
    step(0, 0, 1, 2, 2, "R7 close on cause2");
    step(1, 0, 1, 0, 0, "R7 set+clear empty opens");
    step(1, 0, 1, 0, 0, "R7 same cause handoff keeps");
    step(0, 0, 1, 0, 0, "R7 close cause0");
    // R9: episode saturation
    for (int k = 0; k < 300; k++) begin
      step(1, 0, 0, 0, 0, "R9 episode open");
      step(0, 0, 1, 0, 0, "R9 episode close");
    end
    // R9: total saturation
    step(1, 1, 0, 0, 1, "R9 long open");
    for (int k = 0; k < 4100; k++) step(0, 0, 0, 0, 1, "R9 long hold");
    step(0, 0, 1, 1, 1, "R9 total saturates");
    step(0, 0, 0, 0, 2, "R9 read cause2");
    @(posedge clk);
    #4;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule